// File: doc/BRIEF.md
# Buffered Parallel-to-Serial Converter

This block turns a parallel word into a serial bit stream through two register stages. A holding register captures the parallel inputs on a rising edge of its own capture strobe. Behind it sits a shift register. The shift register either follows the holding register or shifts in a serial bit on each rising edge of a separate step strobe. A mode select chooses between these two behaviours. Because of the split, a new word can be captured while the previous one is still being shifted out.

Both strobes are ordinary level inputs. Each one is sampled on the single system clock, and a 0-to-1 change counts as an edge. Every state change happens on that system clock edge. The serial output always carries the last shift stage. An active-low output enable gates it: when the output is disabled, a separate valid flag drops and the data bit reads zero. This stands in for a high-impedance pin.

Top module: `latched_piso`

## Requirements
- R1: A synchronous active-high reset clears the holding register and the shift register to zero. During reset, out_valid still follows oe_n.
- R2: A rising edge on cap_strobe (a 0-to-1 change between two system clock samples) copies par_in into the holding register, whatever the mode.
- R3: With mode high (shift), a rising edge on step_strobe moves each stage k into stage k+1 and loads ser_in into stage 0. Stage 0 is bit 0 and the last stage is bit WIDTH-1. The old last-stage bit is dropped, so the bits fed in appear at ser_out in the order they were fed, WIDTH edges later.
- R4: With mode low (load), the shift register takes the holding register contents on every system clock. Step edges and ser_in have no effect in this mode.
- R5: With mode low, a cap_strobe edge puts par_in into both registers on the same system clock edge, so ser_out shows par_in[WIDTH-1] right after that edge.
- R6: With mode high, a cap_strobe edge and a step_strobe edge in the same cycle act independently: the holding register captures par_in and the shift register shifts.
- R7: ser_out shows the last shift stage, bit WIDTH-1.
- R8: While oe_n is high, out_valid is 0 and ser_out is 0, and the contents of both registers are kept.
- R9: With mode high and no step edge, the shift register holds. A strobe held high for many cycles counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | WIDTH | Parallel word |
| ser_in | input | 1 | Serial bit for stage 0 |
| mode | input | 1 | 1 = shift, 0 = load from holding register |
| cap_strobe | input | 1 | Holding-register capture strobe (rising edge) |
| step_strobe | input | 1 | Shift step strobe (rising edge) |
| oe_n | input | 1 | Active-low output enable |
| ser_out | output | 1 | Last shift stage, zero when disabled |
| out_valid | output | 1 | 1 when the output is enabled |

## Verification
The bench builds the block with WIDTH = 8. At that width a whole word can be shifted out and compared bit by bit after every kind of load. That covers a word captured in shift mode and moved across later, a word loaded in the same cycle as its capture, and a shift combined with a capture. Eight steps also bring within reach the point where serially fed bits reach the output in the order they were fed. The same width is used to show that step strobes in load mode, a strobe held high, and a disabled output all leave the full word unchanged.

// File: rtl/piso_pkg.sv
package piso_pkg;
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } piso_mode_e;

    localparam int unsigned PISO_DEFAULT_WIDTH = 8;
endpackage

// File: rtl/piso_edge_detect.sv
module piso_edge_detect #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise[g] = lvl[g] & ~st_q.prev[g] & ~rst;
    end
endmodule

// File: rtl/piso_store_reg.sv
module piso_store_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] par,
    output logic [W-1:0] next_val,
    output logic [W-1:0] val
);
    typedef struct packed {
        logic [W-1:0] data;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.data = '0;
        end else if (capture) begin
            st_d.data = par;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign next_val = st_d.data;
    assign val      = st_q.data;
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  piso_mode_e   mode,
    input  logic         step,
    input  logic         ser_in,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] val
);
    typedef struct packed {
        logic [W-1:0] stages;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.stages = '0;
        end else if (mode == MODE_LOAD) begin
            st_d.stages = load_val;
        end else if (step) begin
            st_d.stages = {st_q.stages[W-2:0], ser_in};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign val = st_q.stages;
endmodule

// File: rtl/piso_out_gate.sv
module piso_out_gate (
    input  logic oe_n,
    input  logic last_stage,
    output logic ser_out,
    output logic out_valid
);
    always_comb begin
        out_valid = ~oe_n;
        ser_out   = oe_n ? 1'b0 : last_stage;
    end
endmodule

// File: rtl/latched_piso.sv
module latched_piso
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = PISO_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             mode,
    input  logic             cap_strobe,
    input  logic             step_strobe,
    input  logic             oe_n,
    output logic             ser_out,
    output logic             out_valid
);
    localparam int unsigned NSTROBE = 2;
    localparam int unsigned CAP_IDX  = 0;
    localparam int unsigned STEP_IDX = 1;

    logic [NSTROBE-1:0] strobe_lvl, strobe_rise;
    logic [WIDTH-1:0]   hold_next, hold_q, shift_q;
    piso_mode_e         mode_e;

    assign strobe_lvl = {step_strobe, cap_strobe};
    assign mode_e     = piso_mode_e'(mode);

    piso_edge_detect #(.N(NSTROBE)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  (strobe_lvl),
        .rise (strobe_rise)
    );

    piso_store_reg #(.W(WIDTH)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .capture  (strobe_rise[CAP_IDX]),
        .par      (par_in),
        .next_val (hold_next),
        .val      (hold_q)
    );

    // load path uses the holding register's next value so capture and load coincide
    piso_shift_reg #(.W(WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_e),
        .step     (strobe_rise[STEP_IDX]),
        .ser_in   (ser_in),
        .load_val (hold_next),
        .val      (shift_q)
    );

    piso_out_gate u_out (
        .oe_n       (oe_n),
        .last_stage (shift_q[WIDTH-1]),
        .ser_out    (ser_out),
        .out_valid  (out_valid)
    );

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (hold_q == '0 && shift_q == '0));

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !strobe_rise[CAP_IDX] |=> $stable(hold_q));

    a_r3_shift_moves: assert property (@(posedge clk) disable iff (rst)
        (mode && strobe_rise[STEP_IDX]) |=>
            (shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0]) && shift_q[0] == $past(ser_in)));

    a_r4_load_tracks: assert property (@(posedge clk) disable iff (rst)
        !mode |=> (shift_q == hold_q));

    a_r8_output_off: assert property (@(posedge clk)
        oe_n |-> (!out_valid && !ser_out));

    a_r9_shift_holds: assert property (@(posedge clk) disable iff (rst)
        (mode && !strobe_rise[STEP_IDX]) |=> $stable(shift_q));
endmodule

// File: tb/tb_latched_piso.sv
module tb_latched_piso;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] par_in;
    logic         ser_in, mode, cap_strobe, step_strobe, oe_n;
    logic         ser_out, out_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    latched_piso #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .par_in(par_in), .ser_in(ser_in), .mode(mode),
        .cap_strobe(cap_strobe), .step_strobe(step_strobe), .oe_n(oe_n),
        .ser_out(ser_out), .out_valid(out_valid)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step_pulse(input logic b);
        ser_in = b; step_strobe = 1'b1; tick();
        step_strobe = 1'b0; tick();
    endtask

    task automatic cap_pulse(input logic [W-1:0] v);
        par_in = v; cap_strobe = 1'b1; tick();
        cap_strobe = 1'b0; tick();
    endtask

    // shift mode: read exp MSB first, feeding fill bits
    task automatic drain(input string req, input logic [W-1:0] exp, input logic [W-1:0] fill);
        mode = 1'b1;
        for (int i = W - 1; i >= 0; i--) begin
            check(req, ser_out, exp[i]);
            step_pulse(fill[i]);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; oe_n = 1'b0; tick(); tick();
        check("R1 valid in reset", out_valid, 1'b1);
        oe_n = 1'b1; tick();
        check("R1 oe in reset", out_valid, 1'b0);
        oe_n = 1'b0; rst = 1'b0; tick();
        check("R1 out after reset", ser_out, 1'b0);
        mode = 1'b0; tick();
        drain("R1 shift zero", 8'h00, 8'h00);
    endtask

    task automatic t_capture_in_shift();
        mode = 1'b1;
        cap_pulse(8'hA5);
        check("R9 no change before load", ser_out, 1'b0);
        mode = 1'b0; tick();
        check("R2 captured msb", ser_out, 1'b1);
        // feed 3C serially while reading A5 out
        drain("R2 captured word", 8'hA5, 8'h3C);
        drain("R3 serial order", 8'h3C, 8'h00);
    endtask

    task automatic t_load_ignores_step();
        mode = 1'b0; tick();
        check("R4 follows hold", ser_out, 1'b1);
        for (int k = 0; k < 3; k++) step_pulse(1'b0);
        check("R4 step ignored", ser_out, 1'b1);
        drain("R4 word intact", 8'hA5, 8'h00);
    endtask

    task automatic t_load_and_capture();
        mode = 1'b0; tick();
        check("R7 shows last stage", ser_out, 1'b1);
        par_in = 8'h5A; cap_strobe = 1'b1; tick();
        check("R5 same edge", ser_out, 1'b0);
        cap_strobe = 1'b0; tick();
    endtask

    task automatic t_both_edges();
        // shift holds 5A; both edges at once in shift mode
        mode = 1'b1; par_in = 8'hFF; ser_in = 1'b1;
        cap_strobe = 1'b1; step_strobe = 1'b1; tick();
        cap_strobe = 1'b0; step_strobe = 1'b0; tick();
        drain("R6 shifted word", 8'hB5, 8'h00);
        mode = 1'b0; tick();
        drain("R6 captured word", 8'hFF, 8'h00);
    endtask

    task automatic t_output_enable();
        mode = 1'b0; cap_pulse(8'h81);
        mode = 1'b1; oe_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R8 valid low", out_valid, 1'b0);
            check("R8 data zero", ser_out, 1'b0);
        end
        oe_n = 1'b0; tick();
        check("R8 valid back", out_valid, 1'b1);
        drain("R8 state kept", 8'h81, 8'h00);
    endtask

    task automatic t_level_hold();
        mode = 1'b0; cap_pulse(8'hC0);
        mode = 1'b1; tick();
        ser_in = 1'b0; step_strobe = 1'b1;
        for (int k = 0; k < 5; k++) tick();
        step_strobe = 1'b0; tick();
        // one shift only: C0 -> 80
        drain("R9 single edge", 8'h80, 8'h00);
    endtask

    task automatic t_mid_reset();
        mode = 1'b0; cap_pulse(8'hFF);
        check("R1 preload", ser_out, 1'b1);
        rst = 1'b1; tick(); rst = 1'b0; tick();
        check("R1 cleared", ser_out, 1'b0);
        drain("R1 cleared shift", 8'h00, 8'h00);
        mode = 1'b0; tick();
        check("R1 cleared hold", ser_out, 1'b0);
    endtask

    initial begin
        rst = 1'b1; par_in = '0; ser_in = 1'b0; mode = 1'b1;
        cap_strobe = 1'b0; step_strobe = 1'b0; oe_n = 1'b0;
        tick();
        t_reset();
        t_capture_in_shift();
        mode = 1'b0; cap_pulse(8'hA5);
        t_load_ignores_step();
        mode = 1'b0; cap_pulse(8'hA5);
        t_load_and_capture();
        t_both_edges();
        t_output_enable();
        t_level_hold();
        t_mid_reset();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule